// File: doc/BRIEF.md
# Burst Address and Cycle Controller

This block is the front end of a pipelined burst memory. On every rising clock edge it samples two active-low start strobes (one for a processor, one for a cache controller), an active-low burst-advance input, three chip selects and an active-low write indication. From these it decides whether the edge starts a burst, continues or suspends one, or deselects the device. It then issues one command to the memory core: an effective word address, a valid flag, a write flag and a deselect flag.

A burst is four beats long. The upper address bits come from the external base address, which is captured when a burst starts. The low two bits come from a 2-bit beat counter. A static order pin picks the sequence. When the pin is low the low bits count up modulo 4 from the start value. When it is high they are the start value XOR the beat number.

The controller is a two-state machine. ST_IDLE means no burst is active. ST_BURST means a burst is active. The transitions are:
- start: from either state to ST_BURST, on a strobe start.
- deselect: from either state to ST_IDLE.
- continue: ST_BURST stays in ST_BURST and either advances or holds the address.
- ignore: ST_IDLE stays in ST_IDLE on a continuation edge.

Top module: `burst_addr_ctrl`

## Requirements
- R1: While reset is active, and after reset is released, `core_valid`, `core_write` and `core_desel` are 0 and no burst is active. A continuation edge before any start issues no command.
- R2: With `order_il` = 0, after a start with low bits s, advance edge k (k = 1, 2, …) gives low address bits (s + k) mod 4. After the fourth beat the bits return to s.
- R3: With `order_il` = 1, advance edge k gives low address bits s XOR (k mod 4).
- R4: An edge with `proc_strb_n` = 0 and all chip selects active (`cs_pri_n` = 0, `cs_hi` = 1, `cs_lo_n` = 0) starts a burst read at `ext_addr`. The cycle after that edge shows `core_addr` = `ext_addr`, `core_valid` = 1 and `core_write` = 0, whatever `wr_n`, `adv_n` and `ctrl_strb_n` are.
- R5: An edge with `proc_strb_n` = 1, `ctrl_strb_n` = 0 and all chip selects active starts a burst at `ext_addr`. `core_write` is 1 exactly when `wr_n` = 0 on that edge.
- R6: With `cs_pri_n` = 1, the processor strobe has no effect. If `ctrl_strb_n` = 0 the edge deselects (`core_desel` = 1, `core_valid` = 0). Otherwise the edge is a continuation.
- R7: With `cs_pri_n` = 0 and either `cs_hi` = 0 or `cs_lo_n` = 1, a low on either strobe deselects the device.
- R8: On a continuation edge with a burst active (both strobes high, or as in R6), `adv_n` = 0 moves to the next burst address and `adv_n` = 1 keeps the same address. In both cases `core_valid` = 1 and `core_write` = NOT `wr_n`.
- R9: A deselect ends the active burst. Later continuation edges give `core_valid` = 0 and `core_write` = 0 until a new start.
- R10: `core_valid` and `core_desel` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_strb_n | input | 1 | Processor start strobe, active low |
| ctrl_strb_n | input | 1 | Controller start strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs_pri_n | input | 1 | Primary chip select, active low |
| cs_hi | input | 1 | Secondary chip select, active high |
| cs_lo_n | input | 1 | Secondary chip select, active low |
| wr_n | input | 1 | Write indication, active low |
| order_il | input | 1 | Static order pin: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W | External base word address |
| core_addr | output | ADDR_W | Effective word address for the core |
| core_valid | output | 1 | Access command for this cycle |
| core_write | output | 1 | Command is a write |
| core_desel | output | 1 | Edge deselected the device |

## Verification
The hardest case to reach is the one where the processor strobe is low but the primary select is high. The edge then has to behave as a plain continuation, or as a deselect when the controller strobe is also low, inside a burst that is already running. The stimulus first starts a normal burst. It then applies that combination on later edges, checks that the address advances, then applies the deselect and confirms that following continuations issue no command. Both burst orders are swept over every start value with wrapping advances and a suspend.

// File: rtl/bac_pkg.sv
package bac_pkg;
    typedef enum logic [1:0] {
        OP_CONT     = 2'd0,
        OP_START_RD = 2'd1,
        OP_START_WR = 2'd2,
        OP_DESEL    = 2'd3
    } bac_op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } bac_state_e;
endpackage

// File: rtl/bac_decode.sv
module bac_decode
    import bac_pkg::*;
(
    input  logic    proc_strb_n,
    input  logic    ctrl_strb_n,
    input  logic    cs_pri_n,
    input  logic    cs_hi,
    input  logic    cs_lo_n,
    input  logic    wr_n,
    output bac_op_e op
);
    logic sec_ok;
    assign sec_ok = cs_hi & ~cs_lo_n;

    always_comb begin
        if (!proc_strb_n && !cs_pri_n) begin
            // processor strobe wins; write input not sampled here
            op = sec_ok ? OP_START_RD : OP_DESEL;
        end else if (!ctrl_strb_n) begin
            if (!cs_pri_n && sec_ok) begin
                op = wr_n ? OP_START_RD : OP_START_WR;
            end else begin
                op = OP_DESEL;
            end
        end else begin
            op = OP_CONT;
        end
    end
endmodule

// File: rtl/bac_burst_ctr.sv
module bac_burst_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] base_in,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int LOW_W = 2;
    localparam int HI_W  = ADDR_W - LOW_W;

    logic [HI_W-1:0]  hi_q;
    logic [LOW_W-1:0] start_q;
    logic [LOW_W-1:0] beat_q;
    logic [LOW_W-1:0] low_lin;
    logic [LOW_W-1:0] low_il;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            hi_q    <= base_in[ADDR_W-1:LOW_W];
            start_q <= base_in[LOW_W-1:0];
            beat_q  <= '0;
        end else if (step) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    assign low_lin  = start_q + beat_q;
    assign low_il   = start_q ^ beat_q;
    assign addr_out = {hi_q, interleave ? low_il : low_lin};

    // R8: a hold edge leaves the address unchanged
    p_hold_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> (addr_out == $past(addr_out)) || (interleave != $past(interleave)));

    // R2: linear advance adds one modulo 4 to the low bits
    p_lin_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !interleave) ##1 !interleave |->
        addr_out[LOW_W-1:0] == $past(addr_out[LOW_W-1:0]) + 2'd1);
endmodule

// File: rtl/burst_addr_ctrl.sv
module burst_addr_ctrl
    import bac_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              proc_strb_n,
    input  logic              ctrl_strb_n,
    input  logic              adv_n,
    input  logic              cs_pri_n,
    input  logic              cs_hi,
    input  logic              cs_lo_n,
    input  logic              wr_n,
    input  logic              order_il,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] core_addr,
    output logic              core_valid,
    output logic              core_write,
    output logic              core_desel
);
    bac_op_e    op;
    bac_state_e state_q, state_d;
    logic       ld, stp;

    bac_decode u_decode (
        .proc_strb_n (proc_strb_n),
        .ctrl_strb_n (ctrl_strb_n),
        .cs_pri_n    (cs_pri_n),
        .cs_hi       (cs_hi),
        .cs_lo_n     (cs_lo_n),
        .wr_n        (wr_n),
        .op          (op)
    );

    bac_burst_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (ld),
        .step       (stp),
        .interleave (order_il),
        .base_in    (ext_addr),
        .addr_out   (core_addr)
    );

    // next state and counter control
    always_comb begin
        state_d = state_q;
        ld      = 1'b0;
        stp     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op == OP_START_RD || op == OP_START_WR) begin
                    state_d = ST_BURST;
                    ld      = 1'b1;
                end
            end
            ST_BURST: begin
                unique case (op)
                    OP_START_RD, OP_START_WR: ld = 1'b1;
                    OP_DESEL:                 state_d = ST_IDLE;
                    OP_CONT:                  stp = ~adv_n;
                endcase
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // command outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_valid <= 1'b0;
            core_write <= 1'b0;
            core_desel <= 1'b0;
        end else begin
            core_valid <= (op == OP_START_RD) || (op == OP_START_WR) ||
                          (op == OP_CONT && state_q == ST_BURST);
            core_write <= (op == OP_START_WR) ||
                          (op == OP_CONT && state_q == ST_BURST && !wr_n);
            core_desel <= (op == OP_DESEL);
        end
    end

    p_proc_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!proc_strb_n && !cs_pri_n && cs_hi && !cs_lo_n) |=>
        (core_valid && !core_write && core_addr == $past(ext_addr)));

    p_pri_off_desel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_pri_n && !ctrl_strb_n) |=> (core_desel && !core_valid));

    p_sec_off_desel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_pri_n && !(cs_hi && !cs_lo_n) && (!proc_strb_n || !ctrl_strb_n)) |=>
        (core_desel && !core_valid));

    p_idle_no_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && proc_strb_n && ctrl_strb_n) |=>
        (!core_valid && !core_write));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({core_valid, core_desel}));
endmodule

// File: tb/burst_addr_ctrl_tb_top.sv
module burst_addr_ctrl_tb_top;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          proc_strb_n, ctrl_strb_n, adv_n, cs_pri_n, cs_hi, cs_lo_n, wr_n, order_il;
    logic [AW-1:0] ext_addr;
    logic [AW-1:0] core_addr;
    logic          core_valid, core_write, core_desel;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    burst_addr_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .proc_strb_n(proc_strb_n), .ctrl_strb_n(ctrl_strb_n), .adv_n(adv_n),
        .cs_pri_n(cs_pri_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n), .wr_n(wr_n),
        .order_il(order_il), .ext_addr(ext_addr),
        .core_addr(core_addr), .core_valid(core_valid),
        .core_write(core_write), .core_desel(core_desel)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        proc_strb_n = 1; ctrl_strb_n = 1; adv_n = 1;
        cs_pri_n = 0; cs_hi = 1; cs_lo_n = 0; wr_n = 1;
    endtask

    // apply current inputs across one edge, then sample mid-cycle
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic cmd(input string req, input int v, input int w, input int d);
        check({req, " valid"}, int'(core_valid), v);
        check({req, " write"}, int'(core_write), w);
        check({req, " desel"}, int'(core_desel), d);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        order_il = 0;
        ext_addr = '0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        cmd("R1 reset", 0, 0, 0);
        rst_n = 1;
        @(negedge clk);
        // continuation with no burst: no command (R1, R9)
        adv_n = 0; wr_n = 0;
        step();
        cmd("R1 idle cont", 0, 0, 0);

        // sweep both orders and every start value
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                int hi;
                hi = (m * 4 + s) * 5 + 3;
                order_il = m[0];
                ext_addr = AW'(hi * 4 + s);
                proc_strb_n = 0; wr_n = 0; adv_n = 0; ctrl_strb_n = 0;
                step();
                cmd("R4 proc start", 1, 0, 0);
                check("R4 start addr", int'(core_addr), (hi * 4 + s) % 256);
                for (int k = 1; k <= 5; k++) begin
                    int lo;
                    adv_n = 0; wr_n = k[0];
                    step();
                    lo = m ? (s ^ (k % 4)) : ((s + k) % 4);
                    check(m ? "R3 il addr" : "R2 lin addr", int'(core_addr), (hi * 4 + lo) % 256);
                    cmd("R8 advance", 1, k[0] ? 0 : 1, 0);
                end
                // suspend: same address
                begin
                    int held;
                    held = int'(core_addr);
                    adv_n = 1; wr_n = 0;
                    step();
                    check("R8 hold addr", int'(core_addr), held);
                    cmd("R8 hold", 1, 1, 0);
                end
            end
        end

        // controller strobe starts
        order_il = 0;
        ext_addr = 8'h5A;
        ctrl_strb_n = 0; wr_n = 0;
        step();
        cmd("R5 ctrl write", 1, 1, 0);
        check("R5 addr", int'(core_addr), 8'h5A);
        ext_addr = 8'h33;
        ctrl_strb_n = 0; wr_n = 1;
        step();
        cmd("R5 ctrl read", 1, 0, 0);
        check("R5 addr rd", int'(core_addr), 8'h33);

        // primary select off: processor strobe ignored, acts as continuation
        ext_addr = 8'hF0;
        cs_pri_n = 1; proc_strb_n = 0; adv_n = 0; wr_n = 1;
        step();
        check("R6 cont addr", int'(core_addr), 8'h30);
        cmd("R6 cont", 1, 0, 0);
        cs_pri_n = 1; ctrl_strb_n = 0;
        step();
        cmd("R6 desel", 0, 0, 1);
        adv_n = 0; wr_n = 0;
        step();
        cmd("R9 after desel", 0, 0, 0);

        // secondary select inactive
        ext_addr = 8'h10; proc_strb_n = 0;
        step();
        proc_strb_n = 0; cs_hi = 0;
        step();
        cmd("R7 proc desel", 0, 0, 1);
        ext_addr = 8'h20; proc_strb_n = 0;
        step();
        ctrl_strb_n = 0; cs_lo_n = 1; wr_n = 0;
        step();
        cmd("R7 ctrl desel", 0, 0, 1);
        adv_n = 0;
        step();
        cmd("R9 no burst", 0, 0, 0);

        // processor strobe has priority over controller strobe
        ext_addr = 8'h44; proc_strb_n = 0; ctrl_strb_n = 0; wr_n = 0;
        step();
        cmd("R4 priority", 1, 0, 0);
        check("R4 priority addr", int'(core_addr), 8'h44);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule